// File: doc/BRIEF.md
# Four-Lane Pipelined Vector Integer Unit

This block runs one element-wise integer operation over two source vectors held in its own register file and writes the results into a destination vector of the same file. A single command names the operation, the two sources, the destination, how many elements to process and, optionally, a per-element write mask. Element i goes to lane i mod 4. Every cycle one group of four consecutive elements enters the four lanes together. Each lane is a six-stage pipeline. Elements never depend on one another, so the pipelines run with no hazard detection and no forwarding.

The register file holds eight vectors of 64 elements. It can be loaded one element at a time and read one element at a time while the unit is idle. Each group of results is also shown on a write-back port in the cycle before it is committed. A command of length VL keeps the unit busy for ceil(VL/4)+6 cycles.

Top module: `vau_top`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `wb_valid_o` are 0 and `wb_we_o` is all zeros.
- R2: Opcode encodings are 0 = add, 1 = subtract (a minus b), 2 = multiply keeping the low 64 bits of the product, 3 = bitwise XOR. Each written destination element i equals op(srcA[i], srcB[i]), where the sources are read before any result of the same command is written. This holds when a source is also the destination.
- R3: Results leave in group order. Group g holds elements 4g..4g+3, and element 4g+l appears on lane l, which is bits [64l+63:64l] of `wb_data_o`, with `wb_grp_o` equal to g.
- R4: If a start is accepted at clock edge E0, then group g is presented on the write-back port (`wb_valid_o` high) in the cycle between edges E0+6+g and E0+7+g. It is written into the register file at the edge that ends that cycle. Exactly ceil(VL/4) groups are presented.
- R5: For VL > 0, `busy_o` is high for exactly ceil(VL/4)+6 consecutive cycles, starting in the cycle after the accepting edge. `done_o` is high only in the last of those cycles, which is the cycle of the final write-back.
- R6: A command with VL = 0 holds `busy_o` for one cycle, with `done_o` high in that cycle. It presents no write-back and changes no register.
- R7: Destination elements with index at or beyond VL keep their old values. In a partially filled final group, the unused lanes have their `wb_we_o` bits at 0.
- R8: When `mask_en_i` is 1 at the start, an element whose bit in `mask_i` (bit i for element i) is 0 still passes through the lane, but its `wb_we_o` bit is 0 and its destination element keeps its old value. When `mask_en_i` is 0, all elements below VL are written.
- R9: A start received while `busy_o` is high is ignored. It changes no register and adds no write-back.
- R10: A load (`ld_en_i`) while idle writes `ld_data_i` into element `ld_idx_i` of vector `ld_reg_i`. A load while `busy_o` is high is ignored. `rd_data_o` shows element `rd_idx_i` of vector `rd_reg_i` in the same cycle.
- R11: A vector length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a command (taken only when idle) |
| op_i | input | 2 | Operation code |
| src_a_i | input | 3 | First source vector index |
| src_b_i | input | 3 | Second source vector index |
| dst_i | input | 3 | Destination vector index |
| vl_i | input | 7 | Number of elements to process |
| mask_en_i | input | 1 | Apply the write mask |
| mask_i | input | 64 | Per-element write mask, bit i for element i |
| ld_en_i | input | 1 | Load one element (idle only) |
| ld_reg_i | input | 3 | Load vector index |
| ld_idx_i | input | 6 | Load element index |
| ld_data_i | input | 64 | Load data |
| rd_reg_i | input | 3 | Read vector index |
| rd_idx_i | input | 6 | Read element index |
| rd_data_o | output | 64 | Read data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Final write-back cycle of a command |
| wb_valid_o | output | 1 | A result group is presented |
| wb_grp_o | output | 4 | Index of the presented group |
| wb_we_o | output | 4 | Per-lane write enable of the presented group |
| wb_data_o | output | 256 | Per-lane results of the presented group |

## Verification
A wrong group counter or stage tracker shows on the write-back port in the very cycle it matters: a group arrives with the wrong index, in the wrong cycle, or not at all. The scoreboard compares each presented group against the cycle, index, enables and data it expects. A wrong lane enable or a wrong latched length or mask changes the per-lane write enables immediately. It also leaves stale or overwritten elements, which the read-back of every destination after each command exposes. Faults in the busy and done logic change the busy-cycle count, which is compared for every command.

// File: rtl/vau_pkg.sv
package vau_pkg;
  typedef enum logic [1:0] {
    VAU_ADD = 2'd0,
    VAU_SUB = 2'd1,
    VAU_MUL = 2'd2,
    VAU_XOR = 2'd3
  } vau_op_e;
endpackage

// File: rtl/vau_regfile.sv
module vau_regfile #(
  parameter int W     = 64,
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int LANES = 4,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(LANES),
  localparam int GW = IW - LW
) (
  input  logic                 clk,
  input  logic                 ld_en,
  input  logic [RW-1:0]        ld_reg,
  input  logic [IW-1:0]        ld_idx,
  input  logic [W-1:0]         ld_data,
  input  logic [LANES-1:0]     wr_we,
  input  logic [RW-1:0]        wr_reg,
  input  logic [GW-1:0]        wr_grp,
  input  logic [LANES*W-1:0]   wr_data,
  input  logic [RW-1:0]        a_reg,
  input  logic [RW-1:0]        b_reg,
  input  logic [GW-1:0]        rd_grp,
  output logic [LANES*W-1:0]   a_data,
  output logic [LANES*W-1:0]   b_data,
  input  logic [RW-1:0]        rd_reg,
  input  logic [IW-1:0]        rd_idx,
  output logic [W-1:0]         rd_data
);
  logic [W-1:0] mem_q [NREG][NELEM];

  // Lane writes and loads never coincide: the top gates loads with busy.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_we[l]) mem_q[wr_reg][{wr_grp, LW'(l)}] <= wr_data[l*W +: W];
    end
    if (ld_en) mem_q[ld_reg][ld_idx] <= ld_data;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      a_data[l*W +: W] = mem_q[a_reg][{rd_grp, LW'(l)}];
      b_data[l*W +: W] = mem_q[b_reg][{rd_grp, LW'(l)}];
    end
    rd_data = mem_q[rd_reg][rd_idx];
  end
endmodule

// File: rtl/vau_lane.sv
module vau_lane import vau_pkg::*; #(
  parameter int W     = 64,
  parameter int DEPTH = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         in_we,
  input  vau_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_vld,
  output logic         out_we,
  output logic [W-1:0] out_data
);
  logic [DEPTH-1:0] vld_q, vld_d, we_q, we_d;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     res;

  always_comb begin
    unique case (op)
      VAU_ADD: res = a + b;
      VAU_SUB: res = a - b;
      VAU_MUL: res = a * b;
      default: res = a ^ b;
    endcase
  end

  always_comb begin
    vld_d = {vld_q[DEPTH-2:0], in_vld};
    we_d  = {we_q[DEPTH-2:0], in_vld & in_we};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      we_q  <= '0;
    end else begin
      vld_q <= vld_d;
      we_q  <= we_d;
    end
  end

  // Data stages carry no reset; each loads only when its input is valid.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (in_vld) dat_q[0] <= res;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_we   = we_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];
endmodule

// File: rtl/vau_ctrl.sv
module vau_ctrl import vau_pkg::*; #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int LANES = 4,
  parameter int DEPTH = 6,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(NELEM),
  localparam int LW  = $clog2(LANES),
  localparam int GW  = IW - LW,
  localparam int VLW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [RW-1:0]    src_a_i,
  input  logic [RW-1:0]    src_b_i,
  input  logic [RW-1:0]    dst_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             mask_en_i,
  input  logic [NELEM-1:0] mask_i,
  output logic             busy_o,
  output logic             done_o,
  output vau_op_e          op_o,
  output logic [RW-1:0]    src_a_o,
  output logic [RW-1:0]    src_b_o,
  output logic [RW-1:0]    dst_o,
  output logic [GW-1:0]    iss_grp_o,
  output logic [LANES-1:0] iss_vld_o,
  output logic [LANES-1:0] iss_we_o,
  output logic             wb_vld_o,
  output logic [GW-1:0]    wb_grp_o
);
  logic             active_q, active_d;
  logic [GW-1:0]    grp_q, grp_d;
  logic [VLW-1:0]   vl_q;
  logic             men_q;
  logic [NELEM-1:0] mask_q;
  vau_op_e          op_q;
  logic [RW-1:0]    sa_q, sb_q, dst_q;
  logic [DEPTH-1:0] trk_q, trk_d;
  logic [GW-1:0]    gp_q [DEPTH];

  logic           accept, issue, last_grp;
  logic [VLW:0]   grp_base;

  always_comb begin
    busy_o   = active_q | (|trk_q);
    accept   = start_i & ~busy_o;
    issue    = active_q & (vl_q != '0);
    grp_base = (VLW+1)'({grp_q, {LW{1'b0}}});
    last_grp = (grp_base + (VLW+1)'(LANES)) >= {1'b0, vl_q};

    active_d = active_q;
    grp_d    = grp_q;
    if (accept) begin
      active_d = 1'b1;
      grp_d    = '0;
    end else if (active_q) begin
      if (vl_q == '0 || last_grp) active_d = 1'b0;
      if (issue) grp_d = grp_q + 1'b1;
    end
    trk_d  = {trk_q[DEPTH-2:0], issue};
    done_o = busy_o & ~active_d & ~(|trk_d);
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      iss_vld_o[l] = issue & ({1'b0, grp_q, LW'(l)} < vl_q);
      iss_we_o[l]  = iss_vld_o[l] & (~men_q | mask_q[{grp_q, LW'(l)}]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      grp_q    <= '0;
      trk_q    <= '0;
    end else begin
      active_q <= active_d;
      grp_q    <= grp_d;
      trk_q    <= trk_d;
    end
  end

  // Command fields latch on acceptance only; no reset needed.
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= vau_op_e'(op_i);
      sa_q   <= src_a_i;
      sb_q   <= src_b_i;
      dst_q  <= dst_i;
      vl_q   <= (vl_i > VLW'(NELEM)) ? VLW'(NELEM) : vl_i;
      men_q  <= mask_en_i;
      mask_q <= mask_i;
    end
  end

  // Group index travels alongside the lane pipelines.
  for (genvar s = 0; s < DEPTH; s++) begin : g_gp
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (trk_d[0]) gp_q[0] <= grp_q;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (trk_d[s]) gp_q[s] <= gp_q[s-1];
      end
    end
  end

  assign op_o      = op_q;
  assign src_a_o   = sa_q;
  assign src_b_o   = sb_q;
  assign dst_o     = dst_q;
  assign iss_grp_o = grp_q;
  assign wb_vld_o  = trk_q[DEPTH-1];
  assign wb_grp_o  = gp_q[DEPTH-1];
endmodule

// File: rtl/vau_top.sv
module vau_top import vau_pkg::*; #(
  parameter int W     = 64,
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int LANES = 4,
  parameter int DEPTH = 6,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(NELEM),
  localparam int LW  = $clog2(LANES),
  localparam int GW  = IW - LW,
  localparam int VLW = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         op_i,
  input  logic [RW-1:0]      src_a_i,
  input  logic [RW-1:0]      src_b_i,
  input  logic [RW-1:0]      dst_i,
  input  logic [VLW-1:0]     vl_i,
  input  logic               mask_en_i,
  input  logic [NELEM-1:0]   mask_i,
  input  logic               ld_en_i,
  input  logic [RW-1:0]      ld_reg_i,
  input  logic [IW-1:0]      ld_idx_i,
  input  logic [W-1:0]       ld_data_i,
  input  logic [RW-1:0]      rd_reg_i,
  input  logic [IW-1:0]      rd_idx_i,
  output logic [W-1:0]       rd_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               wb_valid_o,
  output logic [GW-1:0]      wb_grp_o,
  output logic [LANES-1:0]   wb_we_o,
  output logic [LANES*W-1:0] wb_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  vau_op_e          op_q;
  logic [RW-1:0]    sa_q, sb_q, dst_q;
  logic [GW-1:0]    iss_grp;
  logic [LANES-1:0] iss_vld, iss_we, lane_vld, lane_we;
  logic [LANES*W-1:0] a_data, b_data;
  logic             ld_ok;

  vau_ctrl #(.NREG(NREG), .NELEM(NELEM), .LANES(LANES), .DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .dst_i     (dst_i),
    .vl_i      (vl_i),
    .mask_en_i (mask_en_i),
    .mask_i    (mask_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .op_o      (op_q),
    .src_a_o   (sa_q),
    .src_b_o   (sb_q),
    .dst_o     (dst_q),
    .iss_grp_o (iss_grp),
    .iss_vld_o (iss_vld),
    .iss_we_o  (iss_we),
    .wb_vld_o  (wb_valid_o),
    .wb_grp_o  (wb_grp_o)
  );

  assign ld_ok = ld_en_i & ~busy_o;

  vau_regfile #(.W(W), .NREG(NREG), .NELEM(NELEM), .LANES(LANES)) rf_i (
    .clk     (clk),
    .ld_en   (ld_ok),
    .ld_reg  (ld_reg_i),
    .ld_idx  (ld_idx_i),
    .ld_data (ld_data_i),
    .wr_we   (wb_we_o),
    .wr_reg  (dst_q),
    .wr_grp  (wb_grp_o),
    .wr_data (wb_data_o),
    .a_reg   (sa_q),
    .b_reg   (sb_q),
    .rd_grp  (iss_grp),
    .a_data  (a_data),
    .b_data  (b_data),
    .rd_reg  (rd_reg_i),
    .rd_idx  (rd_idx_i),
    .rd_data (rd_data_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vau_lane #(.W(W), .DEPTH(DEPTH)) lane_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .in_vld   (iss_vld[l]),
      .in_we    (iss_we[l]),
      .op       (op_q),
      .a        (a_data[l*W +: W]),
      .b        (b_data[l*W +: W]),
      .out_vld  (lane_vld[l]),
      .out_we   (lane_we[l]),
      .out_data (wb_data_o[l*W +: W])
    );
  end

  assign wb_we_o = lane_vld & lane_we;
endmodule

// File: rtl/vau_top_checker.sv
module vau_top_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             wb_valid_o,
  input logic [LANES-1:0] wb_we_o
);
  assert_done_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  assert_busy_holds_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_wb_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> busy_o);

  assert_enables_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid_o |-> (wb_we_o == '0));

  assert_busy_rises_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind vau_top vau_top_checker #(.LANES(LANES)) vau_chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .wb_valid_o (wb_valid_o),
  .wb_we_o    (wb_we_o)
);

// File: tb/vau_top_tb_top.sv
module vau_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, start_i, mask_en_i, ld_en_i;
  logic [1:0]   op_i;
  logic [2:0]   src_a_i, src_b_i, dst_i, ld_reg_i, rd_reg_i;
  logic [6:0]   vl_i;
  logic [63:0]  mask_i, ld_data_i, rd_data_o;
  logic [5:0]   ld_idx_i, rd_idx_i;
  logic         busy_o, done_o, wb_valid_o;
  logic [3:0]   wb_grp_o, wb_we_o;
  logic [255:0] wb_data_o;

  vau_top dut_i (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           cyc;
    logic [3:0]   grp;
    logic [3:0]   we;
    logic [255:0] data;
  } exp_t;
  exp_t sb[$];

  logic [63:0] mdl [8][64];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] opf(input int op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return a ^ b;
    endcase
  endfunction

  // Monitor: pops one expected group per presented write-back.
  always @(negedge clk) begin
    if (rst_n && wb_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected write-back", 64'(wb_grp_o), 64'hffff);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.cyc, "R4 write-back cycle", 64'(cyc), 64'(e.cyc));
        chk(wb_grp_o == e.grp, "R3 group index", 64'(wb_grp_o), 64'(e.grp));
        chk(wb_we_o == e.we, "R7 R8 lane enables", 64'(wb_we_o), 64'(e.we));
        for (int l = 0; l < 4; l++)
          if (e.we[l])
            chk(wb_data_o[l*64 +: 64] == e.data[l*64 +: 64], "R2 R3 lane result",
                wb_data_o[l*64 +: 64], e.data[l*64 +: 64]);
      end
    end
  end

  task automatic check_reg(input int r, input string req);
    bit ok = 1'b1;
    logic [63:0] a = '0, x = '0;
    for (int i = 0; i < 64; i++) begin
      rd_reg_i = 3'(r);
      rd_idx_i = 6'(i);
      #1;
      if (ok && rd_data_o !== mdl[r][i]) begin
        ok = 1'b0;
        a = rd_data_o;
        x = mdl[r][i];
      end
    end
    chk(ok, req, a, x);
    @(negedge clk);
  endtask

  task automatic load_reg(input int r);
    for (int i = 0; i < 64; i++) begin
      ld_en_i   = 1'b1;
      ld_reg_i  = 3'(r);
      ld_idx_i  = 6'(i);
      ld_data_i = (64'h0123_4567_89ab_cdef * 64'(r * 64 + i + 3)) ^ (64'(i) << 40);
      mdl[r][i] = ld_data_i;
      @(negedge clk);
    end
    ld_en_i = 1'b0;
  endtask

  task automatic run_op(input int op, input int a, input int b, input int d, input int vl,
                        input bit men, input logic [63:0] mask,
                        input int inj_start, input int inj_ld);
    int eff = (vl > 64) ? 64 : vl;
    int ng  = (eff + 3) / 4;
    int c0, bc, dcyc, exp_bc;
    logic [63:0] nv [64];
    while (busy_o) @(negedge clk);
    op_i = 2'(op); src_a_i = 3'(a); src_b_i = 3'(b); dst_i = 3'(d);
    vl_i = 7'(vl); mask_en_i = men; mask_i = mask; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    c0 = cyc;
    for (int i = 0; i < 64; i++) nv[i] = mdl[d][i];
    for (int g = 0; g < ng; g++) begin
      exp_t e;
      e.cyc = c0 + 6 + g; e.grp = 4'(g); e.we = '0; e.data = '0;
      for (int l = 0; l < 4; l++) begin
        int idx = g * 4 + l;
        if (idx < eff && (!men || mask[idx])) begin
          e.we[l] = 1'b1;
          e.data[l*64 +: 64] = opf(op, mdl[a][idx], mdl[b][idx]);
          nv[idx] = e.data[l*64 +: 64];
        end
      end
      sb.push_back(e);
    end
    bc = 0; dcyc = -1;
    while (busy_o) begin
      bc++;
      if (done_o) dcyc = cyc;
      if (inj_start >= 0 && cyc == c0 + 2) begin
        start_i = 1'b1; dst_i = 3'(inj_start);
      end else start_i = 1'b0;
      if (inj_ld >= 0 && cyc == c0 + 3) begin
        ld_en_i = 1'b1; ld_reg_i = 3'(inj_ld); ld_idx_i = 6'd0; ld_data_i = ~mdl[inj_ld][0];
      end else ld_en_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0; ld_en_i = 1'b0;
    exp_bc = (eff == 0) ? 1 : ng + 6;
    chk(bc == exp_bc, (eff == 0) ? "R6 busy length" : "R5 busy length", 64'(bc), 64'(exp_bc));
    chk(dcyc == c0 + exp_bc - 1, (eff == 0) ? "R6 done cycle" : "R5 done cycle",
        64'(dcyc), 64'(c0 + exp_bc - 1));
    chk(sb.size() == 0, "R4 all groups presented", 64'(sb.size()), 64'd0);
    for (int i = 0; i < 64; i++) mdl[d][i] = nv[i];
    check_reg(d, "R2 R7 R8 R11 destination contents");
    if (inj_start >= 0) check_reg(inj_start, "R9 start while busy ignored");
    if (inj_ld >= 0) check_reg(inj_ld, "R10 load while busy ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mask_en_i = 1'b0; ld_en_i = 1'b0;
    op_i = '0; src_a_i = '0; src_b_i = '0; dst_i = '0; vl_i = '0;
    mask_i = '0; ld_data_i = '0; ld_reg_i = '0; ld_idx_i = '0; rd_reg_i = '0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !wb_valid_o && wb_we_o == 0, "R1 state in reset",
        {busy_o, done_o, wb_valid_o, wb_we_o}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !wb_valid_o && wb_we_o == 0, "R1 state after reset",
        {busy_o, done_o, wb_valid_o, wb_we_o}, 64'd0);

    for (int r = 0; r < 8; r++) load_reg(r);
    check_reg(0, "R10 load and read back");
    check_reg(7, "R10 load and read back");

    run_op(0, 0, 1, 2, 64, 1'b0, '0, -1, -1);                  // full add
    run_op(1, 3, 0, 3, 13, 1'b0, '0, -1, -1);                  // subtract, tail R7
    run_op(2, 1, 5, 4, 64, 1'b1, 64'hAAAA_5555_F0F0_0F0F, -1, -1); // masked multiply R8
    run_op(3, 2, 4, 5, 6, 1'b1, 64'h2D, 6, 7);                 // XOR, R9 R10 injections
    run_op(0, 0, 1, 6, 0, 1'b0, '0, -1, -1);                   // empty command R6
    run_op(0, 2, 3, 7, 100, 1'b0, '0, -1, -1);                 // oversize length R11
    run_op(2, 1, 1, 1, 37, 1'b0, '0, 4, -1);                   // source equals destination
    run_op(1, 7, 6, 0, 1, 1'b0, '0, -1, 3);                    // single element

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule